// File: doc/BRIEF.md
# Width-Configurable FIFO with Byte Ordering

This block is a single-clock first-in first-out buffer whose write bus and read bus are each set to either 18 or 9 bits while master reset is held low. Storage is organised as 18-bit words built from two 9-bit halves. When the write side is wide and the read side is narrow, every stored word leaves the buffer as two bytes. When the write side is narrow and the read side is wide, two successive bytes are joined into one word. An endian input, sampled at the same time as the widths, decides which half of a word travels first. With both buses narrow, the word storage is addressed by byte, so the buffer holds twice as many entries.

The configuration is latched into a bus-mode register that has four states: `MODE_W18_R18`, `MODE_W18_R9`, `MODE_W9_R18` and `MODE_W9_R9`. This register can only change while `mrst_n` is low. The write controller has two states. It moves from `WS_WHOLE` to `WS_PAIR` when it accepts the first byte of a pair, and returns to `WS_WHOLE` when it commits the joined word. This two-state sequence is used only in `MODE_W9_R18`. The read controller also has two states. It moves from `RS_FIRST` to `RS_SECOND` when it hands out the first byte of a word, and returns to `RS_FIRST` when it hands out the second byte and frees the word. This two-state sequence is used only in `MODE_W18_R9`.

Both status outputs are active low. The fill level is counted in units of the wider selected bus. Read data is registered, so it appears on the clock edge that accepts the read.

Top module: `bmf_fifo`

## Requirements
- R1: `cfg_in_wide`, `cfg_out_wide` and `cfg_little` are sampled only on clock edges where `mrst_n` is low. Changing them after reset has no effect on the bus widths or on the byte order.
- R2: With both buses wide (`cfg_in_wide`=1, `cfg_out_wide`=1), 18-bit words are read back unchanged and in the order they were written.
- R3: With a wide write bus, a narrow read bus and `cfg_little`=0 (big-endian), each word is returned as two reads. The first read gives bits [17:9] of the word and the second read gives bits [8:0]. Each byte appears on `rd_data[8:0]`, and `rd_data[17:9]` reads as zero.
- R4: Under the same widths with `cfg_little`=1 (little-endian), the first read gives bits [8:0] of the word and the second read gives bits [17:9].
- R5: With a narrow write bus and a wide read bus, only `wr_data[8:0]` is used, and two successive writes form one word. In big-endian mode the first byte lands in bits [17:9]. In little-endian mode the first byte lands in bits [8:0]. The word becomes readable only after its second byte has been written, so `empty_n` stays low after the first byte.
- R6: When either bus is wide, the capacity is DEPTH words. `full_n` goes low after exactly DEPTH word writes with no reads, or after exactly 2*DEPTH byte writes in narrow-write mode. Before that point it stays high.
- R7: With both buses narrow, the capacity is 2*DEPTH bytes. `full_n` goes low after exactly 2*DEPTH writes with no reads, and the bytes come back in the order they were written.
- R8: A write request while `full_n` is low is ignored. The stored contents and the fill level stay unchanged.
- R9: A read request while `empty_n` is low is ignored. `rd_data` holds its previous value and `empty_n` stays low.
- R10: In wide-write/narrow-read mode, a word is freed only after its second byte has been read. After the first byte of the only stored word has been read, `empty_n` stays high.
- R11: After master reset, `full_n`=1, `empty_n`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; latches configuration |
| cfg_in_wide | input | 1 | 1 = 18-bit write bus, 0 = 9-bit write bus |
| cfg_out_wide | input | 1 | 1 = 18-bit read bus, 0 = 9-bit read bus |
| cfg_little | input | 1 | 0 = big-endian, 1 = little-endian |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data; only [8:0] is used on a narrow bus |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Registered read data; [17:9] is zero on a narrow bus |
| full_n | output | 1 | Low when the buffer is full |
| empty_n | output | 1 | Low when the buffer is empty |

## Verification
A read controller stuck in the wrong phase shows up as swapped or repeated bytes on the next read. It also shows up as `empty_n` falling one byte early or late, so the error is visible within two read cycles. A write controller in the wrong phase misaligns every later word, which is visible on the first wide read. A fill level off by one moves the `full_n` edge away from the exact write count, and it leaves a stale or missing word when the buffer is drained.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
    localparam int BYTE_W = 9;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        MODE_W18_R18,
        MODE_W18_R9,
        MODE_W9_R18,
        MODE_W9_R9
    } bus_mode_e;

    typedef enum logic {
        WS_WHOLE,
        WS_PAIR
    } wr_state_e;

    typedef enum logic {
        RS_FIRST,
        RS_SECOND
    } rd_state_e;
endpackage

// File: rtl/bmf_cfg.sv
module bmf_cfg
    import bmf_pkg::*;
(
    input  logic      clk,
    input  logic      mrst_n,
    input  logic      in_wide,
    input  logic      out_wide,
    input  logic      little,
    output bus_mode_e mode,
    output logic      little_q
);
    bus_mode_e mode_d;

    always_comb begin
        unique case ({in_wide, out_wide})
            2'b11:   mode_d = MODE_W18_R18;
            2'b10:   mode_d = MODE_W18_R9;
            2'b01:   mode_d = MODE_W9_R18;
            default: mode_d = MODE_W9_R9;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode     <= mode_d;
            little_q <= little;
        end
    end

    // R1: configuration frozen outside master reset
    a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> ($stable(mode) && $stable(little_q)));
endmodule

// File: rtl/bmf_wr_ctl.sv
module bmf_wr_ctl
    import bmf_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic                clk,
    input  logic                mrst_n,
    input  bus_mode_e           mode,
    input  logic                little,
    input  logic                wr_en,
    input  logic                room,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                commit,
    output logic                we_hi,
    output logic                we_lo,
    output logic [PW-1:0]       addr,
    output logic [BYTE_W-1:0]   din_hi,
    output logic [BYTE_W-1:0]   din_lo
);
    wr_state_e         st, st_nx;
    logic [PW:0]       ptr, ptr_nx;
    logic [BYTE_W-1:0] hold;
    logic              go;

    assign go = wr_en && room;

    always_ff @(posedge clk) begin
        if (!mrst_n) st <= WS_WHOLE;
        else         st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            hold <= '0;
            ptr  <= '0;
        end else begin
            if (go && st == WS_WHOLE && mode == MODE_W9_R18) hold <= wr_data[BYTE_W-1:0];
            if (commit) ptr <= ptr_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        commit = 1'b0;
        we_hi  = 1'b0;
        we_lo  = 1'b0;
        din_hi = wr_data[WORD_W-1:BYTE_W];
        din_lo = wr_data[BYTE_W-1:0];
        unique case (mode)
            MODE_W18_R18, MODE_W18_R9: begin
                if (go) begin
                    commit = 1'b1;
                    we_hi  = 1'b1;
                    we_lo  = 1'b1;
                end
            end
            MODE_W9_R18: begin
                unique case (st)
                    WS_WHOLE: if (go) st_nx = WS_PAIR;
                    WS_PAIR: begin
                        din_hi = little ? wr_data[BYTE_W-1:0] : hold;
                        din_lo = little ? hold : wr_data[BYTE_W-1:0];
                        if (go) begin
                            commit = 1'b1;
                            we_hi  = 1'b1;
                            we_lo  = 1'b1;
                            st_nx  = WS_WHOLE;
                        end
                    end
                endcase
            end
            MODE_W9_R9: begin
                din_hi = wr_data[BYTE_W-1:0];
                if (go) begin
                    commit = 1'b1;
                    we_hi  = ptr[0];
                    we_lo  = !ptr[0];
                end
            end
        endcase
    end

    always_comb begin
        if (mode == MODE_W9_R9) begin
            addr   = ptr[PW:1];
            ptr_nx = ptr + 1'b1;
        end else begin
            addr   = ptr[PW-1:0];
            ptr_nx = {1'b0, PW'(ptr[PW-1:0] + 1'b1)};
        end
    end

    // R5: a pair is open only in the narrow-write/wide-read mode
    a_r5_pair_mode: assert property (@(posedge clk) disable iff (!mrst_n)
        (st == WS_PAIR) |-> (mode == MODE_W9_R18));
endmodule

// File: rtl/bmf_rd_ctl.sv
module bmf_rd_ctl
    import bmf_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic                clk,
    input  logic                mrst_n,
    input  bus_mode_e           mode,
    input  logic                little,
    input  logic                rd_en,
    input  logic                avail,
    input  logic [BYTE_W-1:0]   dout_hi,
    input  logic [BYTE_W-1:0]   dout_lo,
    output logic                pop,
    output logic [PW-1:0]       addr,
    output logic [WORD_W-1:0]   rd_data
);
    rd_state_e         st, st_nx;
    logic [PW:0]       ptr, ptr_nx;
    logic              go, load;
    logic [WORD_W-1:0] nx_data;

    assign go = rd_en && avail;

    always_ff @(posedge clk) begin
        if (!mrst_n) st <= RS_FIRST;
        else         st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            rd_data <= '0;
            ptr     <= '0;
        end else begin
            if (load) rd_data <= nx_data;
            if (pop)  ptr     <= ptr_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        pop     = 1'b0;
        load    = 1'b0;
        nx_data = '0;
        unique case (mode)
            MODE_W18_R18, MODE_W9_R18: begin
                if (go) begin
                    load    = 1'b1;
                    pop     = 1'b1;
                    nx_data = {dout_hi, dout_lo};
                end
            end
            MODE_W18_R9: begin
                unique case (st)
                    RS_FIRST: if (go) begin
                        load    = 1'b1;
                        nx_data = {{BYTE_W{1'b0}}, (little ? dout_lo : dout_hi)};
                        st_nx   = RS_SECOND;
                    end
                    RS_SECOND: if (go) begin
                        load    = 1'b1;
                        pop     = 1'b1;
                        nx_data = {{BYTE_W{1'b0}}, (little ? dout_hi : dout_lo)};
                        st_nx   = RS_FIRST;
                    end
                endcase
            end
            MODE_W9_R9: begin
                if (go) begin
                    load    = 1'b1;
                    pop     = 1'b1;
                    nx_data = {{BYTE_W{1'b0}}, (ptr[0] ? dout_hi : dout_lo)};
                end
            end
        endcase
    end

    always_comb begin
        if (mode == MODE_W9_R9) begin
            addr   = ptr[PW:1];
            ptr_nx = ptr + 1'b1;
        end else begin
            addr   = ptr[PW-1:0];
            ptr_nx = {1'b0, PW'(ptr[PW-1:0] + 1'b1)};
        end
    end

    // R10: a half-read word is still counted as stored
    a_r10_half_word_held: assert property (@(posedge clk) disable iff (!mrst_n)
        (st == RS_SECOND) |-> avail);
    // R9: a read on empty leaves the output register alone
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!mrst_n)
        (rd_en && !avail) |=> $stable(rd_data));
endmodule

// File: rtl/bmf_fifo.sv
module bmf_fifo
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        mrst_n,
    input  logic        cfg_in_wide,
    input  logic        cfg_out_wide,
    input  logic        cfg_little,
    input  logic        wr_en,
    input  logic [17:0] wr_data,
    input  logic        rd_en,
    output logic [17:0] rd_data,
    output logic        full_n,
    output logic        empty_n
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 2;
    localparam logic [CW-1:0] CAP_WORD = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_BYTE = CW'(2 * DEPTH);

    bus_mode_e         mode;
    logic              little_q;
    logic [CW-1:0]     count, cap;
    logic              full, avail;
    logic              commit, pop, we_hi, we_lo;
    logic [PW-1:0]     waddr, raddr;
    logic [BYTE_W-1:0] din_hi, din_lo;
    logic [BYTE_W-1:0] mem_hi [DEPTH];
    logic [BYTE_W-1:0] mem_lo [DEPTH];

    bmf_cfg u_cfg (
        .clk(clk), .mrst_n(mrst_n), .in_wide(cfg_in_wide), .out_wide(cfg_out_wide),
        .little(cfg_little), .mode(mode), .little_q(little_q)
    );

    bmf_wr_ctl #(.PW(PW)) u_wr (
        .clk(clk), .mrst_n(mrst_n), .mode(mode), .little(little_q), .wr_en(wr_en),
        .room(!full), .wr_data(wr_data), .commit(commit), .we_hi(we_hi), .we_lo(we_lo),
        .addr(waddr), .din_hi(din_hi), .din_lo(din_lo)
    );

    bmf_rd_ctl #(.PW(PW)) u_rd (
        .clk(clk), .mrst_n(mrst_n), .mode(mode), .little(little_q), .rd_en(rd_en),
        .avail(avail), .dout_hi(mem_hi[raddr]), .dout_lo(mem_lo[raddr]), .pop(pop),
        .addr(raddr), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (we_hi) mem_hi[waddr] <= din_hi;
        if (we_lo) mem_lo[waddr] <= din_lo;
    end

    assign cap     = (mode == MODE_W9_R9) ? CAP_BYTE : CAP_WORD;
    assign full    = (count == cap);
    assign avail   = (count != '0);
    assign full_n  = !full;
    assign empty_n = avail;

    always_ff @(posedge clk) begin
        if (!mrst_n) count <= '0;
        else begin
            unique case ({commit, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: fill level never exceeds the mode's capacity
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!mrst_n)
        count <= cap);
    // R8: a write into a full buffer does not free space
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!mrst_n)
        (!full_n && wr_en && !rd_en) |=> !full_n);
endmodule

// File: tb/bmf_fifo_test.sv
`timescale 1ns/1ps
module bmf_fifo_test;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        cfg_in_wide = 1'b1, cfg_out_wide = 1'b1, cfg_little = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        full_n, empty_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bmf_fifo #(.DEPTH(D)) uut (
        .clk(clk), .mrst_n(mrst_n), .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide),
        .cfg_little(cfg_little), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .full_n(full_n), .empty_n(empty_n)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic iw, input logic ow, input logic le);
        @(negedge clk);
        mrst_n = 1'b0; cfg_in_wide = iw; cfg_out_wide = ow; cfg_little = le;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        mrst_n = 1'b1;
    endtask

    task automatic wr1(input logic [17:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd1();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 1'b1, 1'b0);
        chk("R11 full_n", 18'(full_n), 18'd1);
        chk("R11 empty_n", 18'(empty_n), 18'd0);
        chk("R11 rd_data", rd_data, 18'd0);
    endtask

    task automatic t_wide();
        do_reset(1'b1, 1'b1, 1'b0);
        wr1(18'h2A5A5); wr1(18'h01234); wr1(18'h3FFFF);
        rd1(); chk("R2 word0", rd_data, 18'h2A5A5);
        rd1(); chk("R2 word1", rd_data, 18'h01234);
        rd1(); chk("R2 word2", rd_data, 18'h3FFFF);
        chk("R2 drained", 18'(empty_n), 18'd0);
    endtask

    task automatic t_split(input logic le);
        do_reset(1'b1, 1'b0, le);
        wr1({9'h1A3, 9'h05C});
        rd1();
        chk(le ? "R4 first byte" : "R3 first byte", rd_data, le ? 18'h0005C : 18'h001A3);
        chk("R10 word kept after one byte", 18'(empty_n), 18'd1);
        rd1();
        chk(le ? "R4 second byte" : "R3 second byte", rd_data, le ? 18'h001A3 : 18'h0005C);
        chk("R10 word freed after two bytes", 18'(empty_n), 18'd0);
    endtask

    task automatic t_pack(input logic le);
        do_reset(1'b0, 1'b1, le);
        wr1({9'h1FF, 9'h1A3});
        chk("R5 half word not readable", 18'(empty_n), 18'd0);
        wr1({9'h155, 9'h05C});
        chk("R5 word committed", 18'(empty_n), 18'd1);
        rd1();
        chk("R5 packed word", rd_data, le ? {9'h05C, 9'h1A3} : {9'h1A3, 9'h05C});
    endtask

    task automatic t_cap_wide();
        do_reset(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < D - 1; i++) wr1(18'h100 + 18'(i));
        chk("R6 not full at D-1", 18'(full_n), 18'd1);
        wr1(18'h100 + 18'(D - 1));
        chk("R6 full at D", 18'(full_n), 18'd0);
        wr1(18'h3FFFF);
        chk("R8 still full", 18'(full_n), 18'd0);
        for (int i = 0; i < D; i++) begin
            rd1();
            chk("R8 contents intact", rd_data, 18'h100 + 18'(i));
        end
        chk("R8 extra word absent", 18'(empty_n), 18'd0);
        rd1();
        chk("R9 data held on empty read", rd_data, 18'h100 + 18'(D - 1));
        chk("R9 still empty", 18'(empty_n), 18'd0);
    endtask

    task automatic t_cap_pack();
        do_reset(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 2 * D - 1; i++) wr1(18'h40 + 18'(i));
        chk("R6 narrow write not full at 2D-1", 18'(full_n), 18'd1);
        wr1(18'h40 + 18'(2 * D - 1));
        chk("R6 narrow write full at 2D", 18'(full_n), 18'd0);
        for (int k = 0; k < D; k++) begin
            rd1();
            chk("R6 packed contents", rd_data, {9'(9'h40 + 2 * k), 9'(9'h41 + 2 * k)});
        end
    endtask

    task automatic t_narrow();
        do_reset(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 2 * D - 1; i++) wr1({9'h1FF, 9'(9'h80 + i)});
        chk("R7 not full at 2D-1", 18'(full_n), 18'd1);
        wr1({9'h1FF, 9'(9'h80 + 2 * D - 1)});
        chk("R7 full at 2D", 18'(full_n), 18'd0);
        for (int i = 0; i < 2 * D; i++) begin
            rd1();
            chk("R7 byte order", rd_data, {9'h000, 9'(9'h80 + i)});
        end
        chk("R7 drained", 18'(empty_n), 18'd0);
    endtask

    task automatic t_cfg_latch();
        do_reset(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        cfg_out_wide = 1'b1; cfg_little = 1'b1;
        wr1({9'h0F0, 9'h10F});
        rd1();
        chk("R1 narrow big-endian kept", rd_data, 18'h000F0);
        rd1();
        chk("R1 second byte", rd_data, 18'h0010F);
    endtask

    initial begin
        t_reset();
        t_wide();
        t_split(1'b0);
        t_split(1'b1);
        t_pack(1'b0);
        t_pack(1'b1);
        t_cap_wide();
        t_cap_pack();
        t_narrow();
        t_cfg_latch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule